// File: doc/BRIEF.md
# Majority-Vote UART Receiver

This block turns an asynchronous serial input into characters. It does not divide the clock. An oversampling strobe, `tick`, is supplied from outside with 16 strobes per bit time by default, and the block counts those strobes to find the middle of each bit. Every bit decision, the start bit included, comes from a majority vote over 1, 3, 5 or 7 samples centred on mid-bit. The wider windows reject short spikes on a noisy line.

Each finished character goes to an external receive FIFO as a single-cycle push. The push carries the data byte and its parity, frame and break flags. If the FIFO reports full, the character is dropped and a sticky overrun bit is set; reading the status clears it. The FIFO hands back the flags of the character at its read port, and the block merges them with the overrun bit and the FIFO-not-empty indication into a five-bit status word.

Word length, parity enable, parity polarity and vote depth are static configuration inputs. Only the first stop bit is examined, so the number of transmitted stop bits has no effect on reception.

Top module: `uart_rxv`

## Requirements
- R1: After reset no push is issued, `status` reads 0 while the FIFO reports empty, and the overrun bit is clear.
- R2: With the default 8-bit, no-parity setting, a well-formed character is assembled LSB first and pushed exactly once with all three error flags clear. The push is a single-cycle pulse issued after the stop-bit decision.
- R3: `cfg_wlen` selects 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3. Bits of `push_data` above the selected length are 0.
- R4: When `cfg_par_en` is 1, one parity bit follows the data. `cfg_par_even` 0 selects odd parity and 1 selects even parity, and `push_pe` is 1 exactly when the received parity bit disagrees with the selected rule.
- R5: A low first stop bit sets `push_fe`. The character is still pushed.
- R6: A line held low from the start bit through the stop bit is pushed as a break: data 0x00, `push_brk` 1, `push_fe` 1 and `push_pe` 0. No further character is taken until the line has been seen high again.
- R7: `cfg_vote` selects a 1, 3, 5 or 7-sample majority window for codes 0, 1, 2 and 3, centred on sample 8 of the 16 samples in a bit. A 3-sample disturbance across mid-bit flips the bit for codes 0 to 2 and is rejected for code 3.
- R8: A falling edge whose start bit is not confirmed low by the vote at mid-bit returns the receiver to idle with no push.
- R9: A character completed while `fifo_full` is 1 is not pushed and sets the overrun bit. The bit stays set until a cycle with `status_rd` high, clears on the following edge, and a new overrun in the same cycle as the read wins.
- R10: `status` bit 0 equals `head_valid`, bit 1 is the overrun bit, and bits 2, 3 and 4 are the parity, frame and break flags of the head character. Bits 2 to 4 are forced to 0 while `head_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| tick | input | 1 | Oversampling strobe, one cycle wide, 16 per bit |
| rxd | input | 1 | Asynchronous serial input, idle high |
| cfg_vote | input | 2 | Majority window select |
| cfg_wlen | input | 2 | Data-bit count select |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd |
| fifo_full | input | 1 | Receive FIFO cannot accept a push |
| head_valid | input | 1 | Receive FIFO holds at least one character |
| head_pe | input | 1 | Parity flag of the head character |
| head_fe | input | 1 | Frame flag of the head character |
| head_brk | input | 1 | Break flag of the head character |
| status_rd | input | 1 | Status is being read; clears overrun |
| push_valid | output | 1 | Push one character into the FIFO |
| push_data | output | 8 | Received data |
| push_pe | output | 1 | Parity error of the pushed character |
| push_fe | output | 1 | Frame error of the pushed character |
| push_brk | output | 1 | Pushed character is a break |
| status | output | 5 | Merged status word |

## Verification
The assertions assume that the line-control inputs do not change while a character is being received. The upper-bit check on pushed data, in particular, reads `cfg_wlen` when the character completes. They also assume that `tick` is a single-cycle pulse with enough idle clocks between strobes for the synchronizer to settle. The stimulus changes configuration only during idle gaps of at least one bit time, and it starts every character just after a strobe, so each sample index falls at a known offset inside the bit. Spikes are then placed at a fixed offset around mid-bit that covers exactly samples 7, 8 and 9.

// File: rtl/uart_rxv_pkg.sv
package uart_rxv_pkg;

   localparam int DATA_W   = 8;
   localparam int VOTE_WIN = 7;
   localparam int HIST_W   = VOTE_WIN - 1;
   localparam int STAT_W   = 5;

   localparam int ST_NE  = 0;
   localparam int ST_OVR = 1;
   localparam int ST_PE  = 2;
   localparam int ST_FE  = 3;
   localparam int ST_BRK = 4;

   typedef enum logic [2:0] {
      S_IDLE,
      S_START,
      S_DATA,
      S_PAR,
      S_STOP
   } rx_state_e;

   // win[0] is the newest sample; mode k uses the 2k+1 newest samples
   function automatic logic majority(input logic [VOTE_WIN-1:0] win,
                                     input logic [1:0]          mode);
      int ones;
      int span;
      ones = 0;
      span = 2 * int'(mode) + 1;
      for (int j = 0; j < VOTE_WIN; j++) begin
         if (j < span && win[j]) ones++;
      end
      return ones > int'(mode);
   endfunction

endpackage

// File: rtl/uart_rxv_sampler.sv
module uart_rxv_sampler
   import uart_rxv_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       tick,
   input  logic       rxd,
   input  logic [1:0] cfg_vote,
   output logic       smp_now,
   output logic       smp_prev,
   output logic       smp_vote
);

   logic              rxd_s;
   logic [HIST_W-1:0] hist;
   logic [VOTE_WIN-1:0] window;

   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
      if (SYNC_STAGES == 0) begin : g_nosync
         assign rxd_s = rxd;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] q;
         always_ff @(posedge clk or posedge rst) begin
            if (rst) begin
               q <= '1;
            end else begin
               q[0] <= rxd;
               for (int i = 1; i < SYNC_STAGES; i++) q[i] <= q[i-1];
            end
         end
         assign rxd_s = q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or posedge rst) begin
      if (rst)       hist <= '1;
      else if (tick) hist <= {hist[HIST_W-2:0], rxd_s};
   end

   assign window   = {hist, rxd_s};
   assign smp_now  = rxd_s;
   assign smp_prev = hist[0];
   assign smp_vote = majority(window, cfg_vote);

   // R7: a window of all-low samples can never vote high
   p_quiet_low_r7: assert property (@(posedge clk) disable iff (rst)
      (tick && window == '0) |-> !smp_vote);

endmodule

// File: rtl/uart_rxv_framer.sv
module uart_rxv_framer
   import uart_rxv_pkg::*;
#(
   parameter int OVERSAMPLE = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              smp_now,
   input  logic              smp_prev,
   input  logic              smp_vote,
   input  logic [1:0]        cfg_vote,
   input  logic [1:0]        cfg_wlen,
   input  logic              cfg_par_en,
   input  logic              cfg_par_even,
   output logic              frame_done,
   output logic [DATA_W-1:0] frame_data,
   output logic              frame_pe,
   output logic              frame_fe,
   output logic              frame_brk
);

   localparam int            IW   = $clog2(OVERSAMPLE);
   localparam logic [IW-1:0] MID  = IW'(OVERSAMPLE / 2);
   localparam logic [IW-1:0] LAST = IW'(OVERSAMPLE - 1);

   generate
      if (OVERSAMPLE < 8) begin : g_bad_os
         $error("OVERSAMPLE must be at least 8 to fit a 7-sample window");
      end
   endgenerate

   rx_state_e         state;
   logic [IW-1:0]     idx;
   logic [IW-1:0]     dec_idx;
   logic [2:0]        bitn;
   logic [2:0]        last_bit;
   logic [DATA_W-1:0] shreg;
   logic              pbit;
   logic              brk_now;

   // window end moves later by k so the window stays centred on MID
   assign dec_idx  = MID + {{(IW-2){1'b0}}, cfg_vote};
   assign last_bit = {1'b0, cfg_wlen} + 3'd4;
   assign brk_now  = !smp_vote && (shreg == '0) && !(cfg_par_en && pbit);

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         state      <= S_IDLE;
         idx        <= '0;
         bitn       <= '0;
         shreg      <= '0;
         pbit       <= 1'b0;
         frame_done <= 1'b0;
         frame_data <= '0;
         frame_pe   <= 1'b0;
         frame_fe   <= 1'b0;
         frame_brk  <= 1'b0;
      end else begin
         frame_done <= 1'b0;
         if (tick) begin
            if (state == S_IDLE) begin
               if (smp_prev && !smp_now) begin
                  state <= S_START;
                  idx   <= IW'(1);
               end
            end else begin
               idx <= (idx == LAST) ? '0 : idx + IW'(1);
               if (idx == dec_idx) begin
                  unique case (state)
                     S_START: begin
                        if (smp_vote) begin
                           state <= S_IDLE;
                        end else begin
                           state <= S_DATA;
                           bitn  <= '0;
                           shreg <= '0;
                           pbit  <= 1'b0;
                        end
                     end
                     S_DATA: begin
                        shreg[bitn] <= smp_vote;
                        if (bitn == last_bit) state <= cfg_par_en ? S_PAR : S_STOP;
                        else                  bitn  <= bitn + 3'd1;
                     end
                     S_PAR: begin
                        pbit  <= smp_vote;
                        state <= S_STOP;
                     end
                     S_STOP: begin
                        frame_done <= 1'b1;
                        frame_data <= shreg;
                        frame_fe   <= ~smp_vote;
                        frame_brk  <= brk_now;
                        frame_pe   <= cfg_par_en & ~brk_now & (^shreg ^ pbit ^ ~cfg_par_even);
                        state      <= S_IDLE;
                     end
                     default: state <= S_IDLE;
                  endcase
               end
            end
         end
      end
   end

   // R2: a finished character always leaves the receiver idle
   p_done_idle_r2: assert property (@(posedge clk) disable iff (rst)
      frame_done |-> state == S_IDLE);

   // R3: bits above the selected word length are zero
   p_upper_clear_r3: assert property (@(posedge clk) disable iff (rst)
      frame_done |-> (frame_data >> ({2'b00, cfg_wlen} + 4'd5)) == '0);

   // R6: a break carries zero data, a frame error and no parity error
   p_break_shape_r6: assert property (@(posedge clk) disable iff (rst)
      (frame_done && frame_brk) |-> (frame_fe && !frame_pe && frame_data == '0));

endmodule

// File: rtl/uart_rxv_status.sv
module uart_rxv_status
   import uart_rxv_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              frame_done,
   input  logic              fifo_full,
   input  logic              status_rd,
   input  logic              head_valid,
   input  logic              head_pe,
   input  logic              head_fe,
   input  logic              head_brk,
   output logic [STAT_W-1:0] status
);

   logic ovr;

   always_ff @(posedge clk or posedge rst) begin
      if (rst)                          ovr <= 1'b0;
      else if (frame_done && fifo_full) ovr <= 1'b1;
      else if (status_rd)               ovr <= 1'b0;
   end

   always_comb begin
      status         = '0;
      status[ST_NE]  = head_valid;
      status[ST_OVR] = ovr;
      status[ST_PE]  = head_valid & head_pe;
      status[ST_FE]  = head_valid & head_fe;
      status[ST_BRK] = head_valid & head_brk;
   end

   // R9: a character lost to a full FIFO raises overrun
   p_overrun_set_r9: assert property (@(posedge clk) disable iff (rst)
      (frame_done && fifo_full) |=> status[ST_OVR]);

   // R9: overrun holds until a read
   p_overrun_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (status[ST_OVR] && !status_rd) |=> status[ST_OVR]);

   // R9: a read with no new loss clears overrun
   p_overrun_clear_r9: assert property (@(posedge clk) disable iff (rst)
      (status_rd && !(frame_done && fifo_full)) |=> !status[ST_OVR]);

   // R10: head flags are hidden while the FIFO is empty
   p_flags_need_head_r10: assert property (@(posedge clk) disable iff (rst)
      !head_valid |-> status[ST_BRK:ST_PE] == '0);

endmodule

// File: rtl/uart_rxv.sv
module uart_rxv
   import uart_rxv_pkg::*;
#(
   parameter int OVERSAMPLE  = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              rxd,
   input  logic [1:0]        cfg_vote,
   input  logic [1:0]        cfg_wlen,
   input  logic              cfg_par_en,
   input  logic              cfg_par_even,
   input  logic              fifo_full,
   input  logic              head_valid,
   input  logic              head_pe,
   input  logic              head_fe,
   input  logic              head_brk,
   input  logic              status_rd,
   output logic              push_valid,
   output logic [DATA_W-1:0] push_data,
   output logic              push_pe,
   output logic              push_fe,
   output logic              push_brk,
   output logic [STAT_W-1:0] status
);

   logic smp_now;
   logic smp_prev;
   logic smp_vote;
   logic fr_done;

   uart_rxv_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick),
      .rxd      (rxd),
      .cfg_vote (cfg_vote),
      .smp_now  (smp_now),
      .smp_prev (smp_prev),
      .smp_vote (smp_vote)
   );

   uart_rxv_framer #(.OVERSAMPLE(OVERSAMPLE)) u_framer (
      .clk          (clk),
      .rst          (rst),
      .tick         (tick),
      .smp_now      (smp_now),
      .smp_prev     (smp_prev),
      .smp_vote     (smp_vote),
      .cfg_vote     (cfg_vote),
      .cfg_wlen     (cfg_wlen),
      .cfg_par_en   (cfg_par_en),
      .cfg_par_even (cfg_par_even),
      .frame_done   (fr_done),
      .frame_data   (push_data),
      .frame_pe     (push_pe),
      .frame_fe     (push_fe),
      .frame_brk    (push_brk)
   );

   uart_rxv_status u_status (
      .clk        (clk),
      .rst        (rst),
      .frame_done (fr_done),
      .fifo_full  (fifo_full),
      .status_rd  (status_rd),
      .head_valid (head_valid),
      .head_pe    (head_pe),
      .head_fe    (head_fe),
      .head_brk   (head_brk),
      .status     (status)
   );

   assign push_valid = fr_done & ~fifo_full;

endmodule

// File: tb/uart_rxv_tb.sv
`timescale 1ns/1ps
module uart_rxv_tb;

   localparam int TDIV   = 4;
   localparam int BITCLK = TDIV * 16;
   localparam int NV     = 16;

   // [29:28] vote [27:26] wlen [25] par_en [24] even [23] flip parity
   // [22] stop level [21:18] glitched data bit + 1 (0 = none)
   // [17:10] data sent [9:2] data expected [1] pe expected [0] fe expected
   localparam logic [29:0] VEC [NV] = '{
      {2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 8'hA5, 8'hA5, 1'b0, 1'b0},
      {2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 8'h3C, 8'h3C, 1'b0, 1'b0},
      {2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 8'hF5, 8'h15, 1'b0, 1'b0},
      {2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 8'hFF, 8'h3F, 1'b0, 1'b0},
      {2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 8'h81, 8'h01, 1'b0, 1'b0},
      {2'd0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 4'd0, 8'h01, 8'h01, 1'b0, 1'b0},
      {2'd0, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 4'd0, 8'h03, 8'h03, 1'b0, 1'b0},
      {2'd0, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 4'd0, 8'h03, 8'h03, 1'b1, 1'b0},
      {2'd0, 2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 4'd0, 8'h00, 8'h00, 1'b1, 1'b0},
      {2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 8'h55, 8'h55, 1'b0, 1'b1},
      {2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 8'h0A, 8'h0A, 1'b0, 1'b1},
      {2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 4'd4, 8'h00, 8'h00, 1'b0, 1'b0},
      {2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 4'd4, 8'h00, 8'h08, 1'b0, 1'b0},
      {2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 4'd4, 8'h00, 8'h08, 1'b0, 1'b0},
      {2'd2, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 4'd4, 8'hFF, 8'hF7, 1'b0, 1'b0},
      {2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 4'd4, 8'hFF, 8'hFF, 1'b0, 1'b0}
   };

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tick = 1'b0;
   logic [1:0] tdiv = '0;
   logic       rxd = 1'b1;
   logic [1:0] cfg_vote = 2'd0;
   logic [1:0] cfg_wlen = 2'd3;
   logic       cfg_par_en = 1'b0;
   logic       cfg_par_even = 1'b0;
   logic       fifo_full = 1'b0;
   logic       head_valid = 1'b0;
   logic       head_pe = 1'b0;
   logic       head_fe = 1'b0;
   logic       head_brk = 1'b0;
   logic       status_rd = 1'b0;
   logic       push_valid;
   logic [7:0] push_data;
   logic       push_pe;
   logic       push_fe;
   logic       push_brk;
   logic [4:0] status;

   int         n_chk = 0;
   int         n_fail = 0;
   int         cap_cnt = 0;
   logic [7:0] cap_data = '0;
   logic       cap_pe = 1'b0;
   logic       cap_fe = 1'b0;
   logic       cap_brk = 1'b0;

   uart_rxv u_dut (
      .clk          (clk),
      .rst          (rst),
      .tick         (tick),
      .rxd          (rxd),
      .cfg_vote     (cfg_vote),
      .cfg_wlen     (cfg_wlen),
      .cfg_par_en   (cfg_par_en),
      .cfg_par_even (cfg_par_even),
      .fifo_full    (fifo_full),
      .head_valid   (head_valid),
      .head_pe      (head_pe),
      .head_fe      (head_fe),
      .head_brk     (head_brk),
      .status_rd    (status_rd),
      .push_valid   (push_valid),
      .push_data    (push_data),
      .push_pe      (push_pe),
      .push_fe      (push_fe),
      .push_brk     (push_brk),
      .status       (status)
   );

   always #10 clk = ~clk;

   always @(negedge clk) begin
      if (rst) begin
         tdiv <= '0;
         tick <= 1'b0;
      end else begin
         tdiv <= tdiv + 2'd1;
         tick <= (tdiv == 2'd3);
      end
   end

   initial begin
      forever begin
         @(negedge clk);
         if (push_valid) begin
            cap_cnt++;
            cap_data = push_data;
            cap_pe   = push_pe;
            cap_fe   = push_fe;
            cap_brk  = push_brk;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic align();
      do @(posedge clk); while (!tick);
      @(negedge clk);
   endtask

   task automatic idle_bits(input int n);
      rxd = 1'b1;
      repeat (n * BITCLK) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] d, input int nb, input bit pen,
                             input bit pbit, input bit stopv, input int gbit);
      int total;
      total = (2 + nb + (pen ? 1 : 0)) * BITCLK;
      align();
      for (int t = 0; t < total; t++) begin
         int   b;
         int   off;
         logic v;
         b   = t / BITCLK;
         off = t % BITCLK;
         if (b == 0)                 v = 1'b0;
         else if (b <= nb)           v = d[b-1];
         else if (pen && b == nb+1)  v = pbit;
         else                        v = stopv;
         if (gbit >= 0 && b == gbit + 1 && off >= 26 && off < 38) v = ~v;
         rxd = v;
         @(negedge clk);
      end
      rxd = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst = 1'b0;
      repeat (4) @(negedge clk);

      // R1: quiet after reset
      chk(status == 5'd0, "R1", "status after reset", status, 0);
      chk(push_valid == 1'b0, "R1", "push after reset", push_valid, 0);
      idle_bits(2);

      // table of frames: R2, R3, R4, R5, R7
      for (int i = 0; i < NV; i++) begin
         logic [29:0] v;
         int          nb;
         logic [7:0]  m;
         logic        pb;
         string       tag;
         v = VEC[i];
         cfg_vote     = v[29:28];
         cfg_wlen     = v[27:26];
         cfg_par_en   = v[25];
         cfg_par_even = v[24];
         nb = 5 + int'(v[27:26]);
         m  = v[17:10] & ((8'h01 << nb) - 8'h01);
         pb = v[24] ? (^m) : ~(^m);
         pb = pb ^ v[23];
         if (v[21:18] != 4'd0) tag = "R7";
         else if (!v[22])      tag = "R5";
         else if (v[25])       tag = "R4";
         else if (v[27:26] != 2'd3) tag = "R3";
         else                  tag = "R2";
         idle_bits(1);
         cap_cnt = 0;
         send_frame(v[17:10], nb, v[25], pb, v[22], int'(v[21:18]) - 1);
         idle_bits(2);
         chk(cap_cnt == 1, tag, $sformatf("vector %0d push count", i), cap_cnt, 1);
         chk(cap_data == v[9:2], tag, $sformatf("vector %0d data", i), cap_data, v[9:2]);
         chk({cap_brk, cap_fe, cap_pe} == {1'b0, v[0], v[1]}, tag,
             $sformatf("vector %0d flags brk/fe/pe", i),
             {cap_brk, cap_fe, cap_pe}, {1'b0, v[0], v[1]});
      end

      cfg_vote = 2'd0; cfg_wlen = 2'd3; cfg_par_en = 1'b0; cfg_par_even = 1'b0;
      idle_bits(1);

      // R8: short low pulses are not characters
      cap_cnt = 0;
      align();
      rxd = 1'b0;
      repeat (16) @(negedge clk);
      rxd = 1'b1;
      idle_bits(12);
      chk(cap_cnt == 0, "R8", "false start, single sample", cap_cnt, 0);
      cfg_vote = 2'd3;
      idle_bits(1);
      align();
      rxd = 1'b0;
      repeat (16) @(negedge clk);
      rxd = 1'b1;
      idle_bits(12);
      chk(cap_cnt == 0, "R8", "false start, 7-sample vote", cap_cnt, 0);
      cfg_vote = 2'd0;
      idle_bits(1);

      // R6: long break gives one zero character, then recovery
      cap_cnt = 0;
      align();
      rxd = 1'b0;
      repeat (20 * BITCLK) @(negedge clk);
      idle_bits(2);
      chk(cap_cnt == 1, "R6", "break push count", cap_cnt, 1);
      chk(cap_data == 8'h00, "R6", "break data", cap_data, 0);
      chk({cap_brk, cap_fe, cap_pe} == 3'b110, "R6", "break flags brk/fe/pe",
          {cap_brk, cap_fe, cap_pe}, 3'b110);
      cap_cnt = 0;
      send_frame(8'h5A, 8, 1'b0, 1'b0, 1'b1, -1);
      idle_bits(2);
      chk(cap_cnt == 1 && cap_data == 8'h5A && !cap_brk, "R6", "frame after break",
          cap_data, 8'h5A);

      // R9: full FIFO drops and sets a sticky overrun
      fifo_full = 1'b1;
      cap_cnt = 0;
      send_frame(8'h11, 8, 1'b0, 1'b0, 1'b1, -1);
      idle_bits(2);
      chk(cap_cnt == 0, "R9", "push while full", cap_cnt, 0);
      chk(status[1] == 1'b1, "R9", "overrun set", status[1], 1);
      fifo_full = 1'b0;
      repeat (100) @(negedge clk);
      chk(status[1] == 1'b1, "R9", "overrun sticky", status[1], 1);
      status_rd = 1'b1;
      @(negedge clk);
      status_rd = 1'b0;
      chk(status[1] == 1'b0, "R9", "overrun cleared by read", status[1], 0);
      cap_cnt = 0;
      send_frame(8'hC3, 8, 1'b0, 1'b0, 1'b1, -1);
      idle_bits(2);
      chk(cap_cnt == 1 && cap_data == 8'hC3, "R9", "push after overrun", cap_data, 8'hC3);

      // R10: status composition
      head_valid = 1'b1; head_pe = 1'b1; head_fe = 1'b0; head_brk = 1'b1;
      @(negedge clk);
      chk(status == 5'b10101, "R10", "status brk+pe head", status, 5'b10101);
      head_pe = 1'b0; head_fe = 1'b1; head_brk = 1'b0;
      @(negedge clk);
      chk(status == 5'b01001, "R10", "status fe head", status, 5'b01001);
      head_valid = 1'b0; head_pe = 1'b1; head_brk = 1'b1;
      @(negedge clk);
      chk(status == 5'b00000, "R10", "flags hidden when empty", status, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule